// File: doc/BRIEF.md
# 24-Hour BCD Time-of-Day Counter

This block keeps the time of day as three two-digit BCD fields: seconds, minutes and hours. Each field has a 4-bit tens digit and a 4-bit units digit. A one-cycle enable, pulsed once per second by a divider elsewhere on the chip, advances the seconds. A seconds rollover carries into the minutes, and a minutes rollover carries into the hours. The hours run from 00 to 23 and then return to 00.

Two step inputs let a user set the time. Each step pulse moves the minutes or the hours forward by one and zeroes the seconds. A minute step never carries into the hours. Every digit register sits in the one system clock domain. No digit output is ever used as a clock. An active-low reset zeroes the whole time asynchronously; it is expected to be released in step with the clock.

Top module: `tod_clock`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, all six digits read 0 (time 00:00:00).
- R2: Every digit stays a valid BCD value. Seconds and minutes tens stay at 5 or below, and units stay at 9 or below. Hours tens stay at 2 or below, and hours units stay at 3 or below while hours tens is 2.
- R3: On a cycle with no tick and no step pulse, all six digits keep their values.
- R4: A tick with no step pulse raises the seconds by one on the next rising edge. From 59 it returns to 00.
- R5: When a tick takes the seconds from 59 to 00, the minutes rise by one, wrapping from 59 to 00. Otherwise a tick leaves the minutes unchanged.
- R6: The hours rise by one only when a tick takes the minutes from 59 to 00. The units digit carries into the tens at 09 and 19, and 23 goes to 00, so 23:59:59 is followed by 00:00:00.
- R7: A minute step pulse raises the minutes by one, wrapping from 59 to 00. It leaves the hours unchanged and sets the seconds to 00.
- R8: An hour step pulse raises the hours by one, wrapping from 23 to 00. It leaves the minutes unchanged and sets the seconds to 00.
- R9: When a step pulse and a tick arrive in the same cycle, the tick is ignored. The seconds go to 00 and no carry comes from the tick.
- R10: Minute and hour step pulses in the same cycle each step their own field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_1hz | input | 1 | One-cycle pulse once per second that advances the time |
| adj_min | input | 1 | Minute step pulse, one step per asserted cycle |
| adj_hour | input | 1 | Hour step pulse, one step per asserted cycle |
| sec_tens | output | 4 | Seconds tens digit (0-5) |
| sec_units | output | 4 | Seconds units digit (0-9) |
| min_tens | output | 4 | Minutes tens digit (0-5) |
| min_units | output | 4 | Minutes units digit (0-9) |
| hr_tens | output | 4 | Hours tens digit (0-2) |
| hr_units | output | 4 | Hours units digit (0-9) |

## Verification
Some rules are checked on every clocked cycle after reset: the digit ranges, holding when nothing is asserted, the one-step advance for each kind of event, the 59-to-00 and 23-to-00 wraps, and step priority over a tick. Reset behaviour is asynchronous, so only the bench scenarios show it. The scenarios also show that long runs of ticks and steps reach exact times. That covers the 09→10 and 19→20 hour carries, a full midnight rollover, and a minute step at 23:59 that must not carry into the hours.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned DIGIT_W    = 4;
  localparam int unsigned NUM_FIELDS = 3;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum int unsigned {
    FLD_SEC  = 0,
    FLD_MIN  = 1,
    FLD_HOUR = 2
  } field_e;

  // Largest tens digit a field reaches before it wraps.
  function automatic digit_t field_max_tens(int unsigned idx);
    return (idx == FLD_HOUR) ? digit_t'(2) : digit_t'(5);
  endfunction

  // Units digit paired with the largest tens digit at the wrap point.
  function automatic digit_t field_max_units(int unsigned idx);
    return (idx == FLD_HOUR) ? digit_t'(3) : digit_t'(9);
  endfunction
endpackage

// File: rtl/tod_bcd_field.sv
module tod_bcd_field #(
  parameter tod_pkg::digit_t MAX_TENS  = 4'd5,
  parameter tod_pkg::digit_t MAX_UNITS = 4'd9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            step_i,
  output tod_pkg::digit_t tens_o,
  output tod_pkg::digit_t units_o,
  output logic            at_max_o
);
  import tod_pkg::*;

  localparam digit_t UNIT_LAST = digit_t'(9);

  digit_t tens_q, units_q;
  digit_t tens_d, units_d;
  logic   upd_en;

  assign at_max_o = (tens_q == MAX_TENS) && (units_q == MAX_UNITS);
  assign upd_en   = clear_i | step_i;

  // Next-state: clear wins, then the field wrap, then the units-to-tens carry.
  always_comb begin
    tens_d  = tens_q;
    units_d = units_q;
    if (clear_i) begin
      tens_d  = '0;
      units_d = '0;
    end else if (step_i) begin
      if (at_max_o) begin
        tens_d  = '0;
        units_d = '0;
      end else if (units_q == UNIT_LAST) begin
        tens_d  = tens_q + digit_t'(1);
        units_d = '0;
      end else begin
        units_d = units_q + digit_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tens_q  <= '0;
      units_q <= '0;
    end else if (upd_en) begin
      tens_q  <= tens_d;
      units_q <= units_d;
    end
  end

  assign tens_o  = tens_q;
  assign units_o = units_q;
endmodule

// File: rtl/tod_step_ctrl.sv
module tod_step_ctrl (
  input  logic tick_i,
  input  logic adj_min_i,
  input  logic adj_hour_i,
  input  logic sec_max_i,
  input  logic min_max_i,
  output logic sec_clear_o,
  output logic sec_step_o,
  output logic min_step_o,
  output logic hour_step_o
);
  logic adj_any;
  logic run;

  always_comb begin
    adj_any     = adj_min_i | adj_hour_i;
    // A step pulse suppresses the tick for that cycle.
    run         = tick_i & ~adj_any;
    sec_clear_o = adj_any;
    sec_step_o  = run;
    min_step_o  = adj_min_i  | (run & sec_max_i);
    hour_step_o = adj_hour_i | (run & sec_max_i & min_max_i);
  end
endmodule

// File: rtl/tod_clock.sv
module tod_clock (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       adj_min,
  input  logic       adj_hour,
  output logic [3:0] sec_tens,
  output logic [3:0] sec_units,
  output logic [3:0] min_tens,
  output logic [3:0] min_units,
  output logic [3:0] hr_tens,
  output logic [3:0] hr_units
);
  import tod_pkg::*;

  digit_t                tens_w  [NUM_FIELDS];
  digit_t                units_w [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] step_w;
  logic [NUM_FIELDS-1:0] clear_w;
  logic [NUM_FIELDS-1:0] max_w;
  logic                  sec_clear;

  tod_step_ctrl ctrl_i (
    .tick_i      (tick_1hz),
    .adj_min_i   (adj_min),
    .adj_hour_i  (adj_hour),
    .sec_max_i   (max_w[FLD_SEC]),
    .min_max_i   (max_w[FLD_MIN]),
    .sec_clear_o (sec_clear),
    .sec_step_o  (step_w[FLD_SEC]),
    .min_step_o  (step_w[FLD_MIN]),
    .hour_step_o (step_w[FLD_HOUR])
  );

  // Only the seconds field is cleared by a step pulse.
  always_comb begin
    clear_w          = '0;
    clear_w[FLD_SEC] = sec_clear;
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    tod_bcd_field #(
      .MAX_TENS  (field_max_tens(g)),
      .MAX_UNITS (field_max_units(g))
    ) field_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (clear_w[g]),
      .step_i   (step_w[g]),
      .tens_o   (tens_w[g]),
      .units_o  (units_w[g]),
      .at_max_o (max_w[g])
    );
  end

  assign sec_tens  = tens_w[FLD_SEC];
  assign sec_units = units_w[FLD_SEC];
  assign min_tens  = tens_w[FLD_MIN];
  assign min_units = units_w[FLD_MIN];
  assign hr_tens   = tens_w[FLD_HOUR];
  assign hr_units  = units_w[FLD_HOUR];
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1hz,
  input logic       adj_min,
  input logic       adj_hour,
  input logic [3:0] sec_tens,
  input logic [3:0] sec_units,
  input logic [3:0] min_tens,
  input logic [3:0] min_units,
  input logic [3:0] hr_tens,
  input logic [3:0] hr_units
);
  logic [6:0] sec_v, min_v, hr_v;
  logic       adj_any, run;

  always_comb begin
    sec_v   = 7'(sec_tens) * 7'd10 + 7'(sec_units);
    min_v   = 7'(min_tens) * 7'd10 + 7'(min_units);
    hr_v    = 7'(hr_tens)  * 7'd10 + 7'(hr_units);
    adj_any = adj_min | adj_hour;
    run     = tick_1hz & ~adj_any;
  end

  p_bcd_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_units <= 4'd9 && min_units <= 4'd9 && hr_units <= 4'd9 &&
    sec_tens <= 4'd5 && min_tens <= 4'd5 && hr_tens <= 4'd2 &&
    (hr_tens != 4'd2 || hr_units <= 4'd3));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && !adj_any) |=> ($stable(sec_v) && $stable(min_v) && $stable(hr_v)));

  p_sec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sec_v != 7'd59) |=>
      (sec_v == $past(sec_v) + 7'd1 && $stable(min_v) && $stable(hr_v)));

  p_min_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sec_v == 7'd59 && min_v != 7'd59) |=>
      (sec_v == 7'd0 && min_v == $past(min_v) + 7'd1 && $stable(hr_v)));

  p_hour_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sec_v == 7'd59 && min_v == 7'd59) |=>
      (sec_v == 7'd0 && min_v == 7'd0 &&
       hr_v == (($past(hr_v) == 7'd23) ? 7'd0 : $past(hr_v) + 7'd1)));

  // R9: the step properties below hold whatever tick_1hz is doing.
  p_adj_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_min && !adj_hour) |=>
      (sec_v == 7'd0 && $stable(hr_v) &&
       min_v == (($past(min_v) == 7'd59) ? 7'd0 : $past(min_v) + 7'd1)));

  p_adj_hour_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_hour && !adj_min) |=>
      (sec_v == 7'd0 && $stable(min_v) &&
       hr_v == (($past(hr_v) == 7'd23) ? 7'd0 : $past(hr_v) + 7'd1)));

  p_adj_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_hour && adj_min) |=>
      (sec_v == 7'd0 &&
       min_v == (($past(min_v) == 7'd59) ? 7'd0 : $past(min_v) + 7'd1) &&
       hr_v == (($past(hr_v) == 7'd23) ? 7'd0 : $past(hr_v) + 7'd1)));
endmodule

bind tod_clock tod_clock_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_1hz  (tick_1hz),
  .adj_min   (adj_min),
  .adj_hour  (adj_hour),
  .sec_tens  (sec_tens),
  .sec_units (sec_units),
  .min_tens  (min_tens),
  .min_units (min_units),
  .hr_tens   (hr_tens),
  .hr_units  (hr_units)
);

// File: tb/tod_clock_tb_top.sv
module tod_clock_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  localparam logic [2:0] OP_TICK      = 3'd0;
  localparam logic [2:0] OP_AMIN      = 3'd1;
  localparam logic [2:0] OP_AHR       = 3'd2;
  localparam logic [2:0] OP_BOTH      = 3'd3;
  localparam logic [2:0] OP_TICK_AMIN = 3'd4;
  localparam logic [2:0] OP_IDLE      = 3'd5;
  localparam logic [2:0] OP_TICK_AHR  = 3'd6;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] cnt;
    logic [7:0] hh;
    logic [7:0] mm;
    logic [7:0] ss;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 23;
  // Each entry: operation held for cnt cycles, then the expected hh:mm:ss.
  localparam vec_t VECS [NVEC] = '{
    '{OP_TICK,      8'd1,  8'd0,  8'd0,  8'd1,  4'd4},  // R4 first tick
    '{OP_TICK,      8'd58, 8'd0,  8'd0,  8'd59, 4'd4},  // R4
    '{OP_TICK,      8'd1,  8'd0,  8'd1,  8'd0,  4'd5},  // R5 seconds wrap carries
    '{OP_AMIN,      8'd58, 8'd0,  8'd59, 8'd0,  4'd7},  // R7
    '{OP_TICK,      8'd59, 8'd0,  8'd59, 8'd59, 4'd4},  // R4
    '{OP_TICK,      8'd1,  8'd1,  8'd0,  8'd0,  4'd6},  // R6 hour carry
    '{OP_AHR,       8'd8,  8'd9,  8'd0,  8'd0,  4'd8},  // R8
    '{OP_AMIN,      8'd59, 8'd9,  8'd59, 8'd0,  4'd7},  // R7
    '{OP_TICK,      8'd60, 8'd10, 8'd0,  8'd0,  4'd6},  // R6 09 -> 10
    '{OP_TICK,      8'd5,  8'd10, 8'd0,  8'd5,  4'd4},  // R4
    '{OP_AMIN,      8'd1,  8'd10, 8'd1,  8'd0,  4'd7},  // R7 clears seconds
    '{OP_AHR,       8'd13, 8'd23, 8'd1,  8'd0,  4'd8},  // R8 through 19 -> 20
    '{OP_AMIN,      8'd58, 8'd23, 8'd59, 8'd0,  4'd7},  // R7
    '{OP_AMIN,      8'd1,  8'd23, 8'd0,  8'd0,  4'd7},  // R7 no carry to hours
    '{OP_AMIN,      8'd59, 8'd23, 8'd59, 8'd0,  4'd7},  // R7
    '{OP_TICK,      8'd60, 8'd0,  8'd0,  8'd0,  4'd6},  // R6 midnight
    '{OP_AHR,       8'd23, 8'd23, 8'd0,  8'd0,  4'd8},  // R8
    '{OP_AHR,       8'd1,  8'd0,  8'd0,  8'd0,  4'd8},  // R8 23 -> 00
    '{OP_TICK,      8'd7,  8'd0,  8'd0,  8'd7,  4'd4},  // R4
    '{OP_IDLE,      8'd10, 8'd0,  8'd0,  8'd7,  4'd3},  // R3 hold
    '{OP_TICK_AMIN, 8'd1,  8'd0,  8'd1,  8'd0,  4'd9},  // R9 step beats tick
    '{OP_BOTH,      8'd1,  8'd1,  8'd2,  8'd0,  4'd10}, // R10
    '{OP_TICK_AHR,  8'd1,  8'd2,  8'd2,  8'd0,  4'd9}   // R9
  };

  logic       clk;
  logic       rst_n;
  logic       tick_1hz, adj_min, adj_hour;
  logic [3:0] sec_tens, sec_units, min_tens, min_units, hr_tens, hr_units;

  int checks;
  int errors;
  bit done;

  tod_clock dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1hz  (tick_1hz),
    .adj_min   (adj_min),
    .adj_hour  (adj_hour),
    .sec_tens  (sec_tens),
    .sec_units (sec_units),
    .min_tens  (min_tens),
    .min_units (min_units),
    .hr_tens   (hr_tens),
    .hr_units  (hr_units)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic drive(input logic [2:0] op);
    tick_1hz = (op == OP_TICK) || (op == OP_TICK_AMIN) || (op == OP_TICK_AHR);
    adj_min  = (op == OP_AMIN) || (op == OP_BOTH) || (op == OP_TICK_AMIN);
    adj_hour = (op == OP_AHR)  || (op == OP_BOTH) || (op == OP_TICK_AHR);
  endtask

  // Hold an operation for cnt rising edges; return at a falling edge with inputs idle.
  task automatic run(input logic [2:0] op, input int cnt);
    drive(op);
    repeat (cnt) @(negedge clk);
    drive(OP_IDLE);
  endtask

  task automatic check_time(input int req, input int hh, input int mm, input int ss);
    int gh, gm, gs;
    bit bcd_ok;
    gh = int'(hr_tens) * 10 + int'(hr_units);
    gm = int'(min_tens) * 10 + int'(min_units);
    gs = int'(sec_tens) * 10 + int'(sec_units);
    checks++;
    if (gh != hh || gm != mm || gs != ss) begin
      errors++;
      $display("FAIL R%0d time got %0d:%0d:%0d expected %0d:%0d:%0d", req, gh, gm, gs, hh, mm, ss);
    end
    // R2: digit ranges
    bcd_ok = sec_units <= 4'd9 && min_units <= 4'd9 && hr_units <= 4'd9 &&
             sec_tens <= 4'd5 && min_tens <= 4'd5 && hr_tens <= 4'd2;
    checks++;
    if (!bcd_ok) begin
      errors++;
      $display("FAIL R2 digits got %h%h:%h%h:%h%h expected valid BCD", hr_tens, hr_units,
               min_tens, min_units, sec_tens, sec_units);
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG && !done) begin
        errors++;
        $display("FAIL watchdog got %0d cycles expected at most %0d", cyc, WATCHDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    drive(OP_IDLE);
    repeat (3) @(negedge clk);
    check_time(1, 0, 0, 0);              // R1 while in reset
    rst_n = 1'b1;
    @(negedge clk);
    check_time(1, 0, 0, 0);              // R1 after release

    for (int i = 0; i < NVEC; i++) begin
      run(VECS[i].op, int'(VECS[i].cnt));
      check_time(int'(VECS[i].req), int'(VECS[i].hh), int'(VECS[i].mm), int'(VECS[i].ss));
    end

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_time(1, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_time(1, 0, 0, 0);

    // R9 at 23:59:59: tick with a minute step must not roll the hours
    run(OP_AHR, 23);
    run(OP_AMIN, 59);
    run(OP_TICK, 59);
    check_time(6, 23, 59, 59);
    run(OP_TICK_AMIN, 1);
    check_time(9, 23, 0, 0);

    // R9 at 23:59:59: tick with an hour step wraps hours only
    run(OP_AMIN, 59);
    run(OP_TICK, 59);
    check_time(6, 23, 59, 59);
    run(OP_TICK_AHR, 1);
    check_time(9, 0, 59, 0);

    // R5: minute carry without hour carry from a mid-hour value
    run(OP_TICK, 60);
    check_time(6, 1, 0, 0);
    run(OP_TICK, 61);
    check_time(5, 1, 1, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule